// File: doc/BRIEF.md
# Character Display Bus Initialization Sequencer

This block sits on the host side of a parallel character-display bus and brings the display controller into a known state without relying on the controller's own power-on reset. After a start pulse it waits out the power-up interval. It then sends three identical "8-bit function" wake writes separated by minimum waits, during which the busy line is never read. In 4-bit mode it then sends a single nibble that switches the controller to 4-bit transfers. After that it sends the four configuration commands, polling the busy flag after each one.

All waits are clock-cycle counts derived from the clock frequency in kHz. Each busy poll is bounded: after a set number of busy answers the block raises a sticky timeout flag, waits a fixed fallback delay, and moves on. Enable pulse width and the setup and hold of the select and data lines are whole numbers of clocks. The configuration inputs are captured when the start pulse is accepted.

Top module: `disp_init_seq`

## Requirements
- R1: After an accepted start, no enable pulse occurs until at least CLK_KHZ*15 cycles (15 ms) have passed.
- R2: The first three enable pulses are instruction writes (select 0, read/write 0) carrying 0x30 on the data lines. At least ceil(CLK_KHZ*4.1) cycles separate the end of the first from the start of the second. At least ceil(CLK_KHZ*0.1) cycles follow the second and the third.
- R3: No read pulse occurs before the three wake writes and, in 4-bit mode, the mode nibble have completed.
- R4: In 4-bit mode (cfg_bus8=0), the wake writes are followed by exactly one pulse carrying 0x20. Each later byte goes out as two pulses: the high nibble on data[7:4] first, then the low nibble on data[7:4], with data[3:0] driven 0.
- R5: The configuration bytes follow in this fixed order, all with select 0: function set 0x20 | bus8<<4 | two_line<<3 | tall_font<<2; display off 0x08; clear 0x01; entry mode 0x04 | incr<<1 | shift.
- R6: After the mode nibble and after each configuration byte, the block issues status reads (select 0, read/write 1) until the flag line reads 0, and only then writes again. In 4-bit mode a status read is two pulses, and the flag is taken from the first.
- R7: After POLL_MAX consecutive busy answers, poll_timeout is set. The block then stays quiet for at least ceil(FALLBACK_US*CLK_KHZ/1000) cycles and continues with the next step. poll_timeout stays set until the next accepted start.
- R8: The enable line stays high for exactly PULSE_CYC cycles. Select, read/write, data and drive-enable are steady for at least SETUP_CYC cycles before it rises, during the pulse, and for at least HOLD_CYC cycles after it falls.
- R9: lcd_doe is high during write pulses and low during read pulses.
- R10: Reset leaves enable, drive-enable, done and poll_timeout at 0. An accepted start clears done. done rises after the last status read and stays set with no further pulses until the next start.
- R11: A start pulse while a sequence is running has no effect: the sequence completes with exactly its normal number of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| cfg_bus8 | input | 1 | 1 selects 8-bit transfers, 0 selects 4-bit |
| cfg_two_line | input | 1 | Line-count flag for the function-set byte |
| cfg_tall_font | input | 1 | Font flag for the function-set byte |
| cfg_addr_incr | input | 1 | Address-increment flag for the entry-mode byte |
| cfg_auto_shift | input | 1 | Shift flag for the entry-mode byte |
| lcd_flag_in | input | 1 | Data line 7 as read back from the display |
| lcd_rs | output | 1 | Register select |
| lcd_rw | output | 1 | Read (1) / write (0) |
| lcd_en | output | 1 | Enable strobe |
| lcd_dout | output | 8 | Data lines driven toward the display |
| lcd_doe | output | 1 | Drive enable for the data lines |
| done | output | 1 | Sequence complete |
| poll_timeout | output | 1 | A busy poll ran out of attempts |

## Verification
The bench builds the block with CLK_KHZ=4, SETUP_CYC=2, PULSE_CYC=3, HOLD_CYC=2, POLL_MAX=4 and FALLBACK_US=2000. With these values the millisecond waits become tens of cycles, so full 8-bit and 4-bit sequences run back to back. A display model that holds the flag for a set time, or holds it busy indefinitely after a chosen command, drives the poll loop both to normal completion and to the timeout fallback. The one-cycle wait after the second and third wake writes checks the shortest legal gap.

// File: rtl/disp_init_pkg.sv
// Shared types and command codes for the display initialization sequencer.
// Assumes an instruction-register command set with function-set, display-control,
// clear and entry-mode bytes at fixed code points.
package disp_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_WAKE,
        ST_WAKE_WAIT,
        ST_NIB,
        ST_CMD,
        ST_POLL,
        ST_FALLBACK,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } xfer_phase_e;

    localparam logic [7:0] WAKE_CODE  = 8'h30;
    localparam logic [7:0] MODE4_CODE = 8'h20;
    localparam logic [7:0] DISP_OFF   = 8'h08;
    localparam logic [7:0] CLEAR_CODE = 8'h01;

    // Configuration byte for step idx of the command phase
    function automatic logic [7:0] cfg_byte(
        input logic [1:0] idx,
        input logic       bus8,
        input logic       two_line,
        input logic       tall,
        input logic       incr,
        input logic       shift
    );
        logic [7:0] b;
        case (idx)
            2'd0:    b = {3'b001, bus8, two_line, tall, 2'b00};
            2'd1:    b = DISP_OFF;
            2'd2:    b = CLEAR_CODE;
            default: b = {5'b00000, 1'b1, incr, shift};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/disp_bus_xfer.sv
// One bus transaction toward the display: setup, enable pulse, hold.
// In nibble mode a full byte takes two strobes (high nibble first) on data[7:4];
// a single-nibble request takes one strobe. Reads capture the flag line at the
// end of the first strobe. Assumes req is only raised while the engine is idle.
module disp_bus_xfer
    import disp_init_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 12,
    parameter int HOLD_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_rd,
    input  logic       req_nib,
    input  logic       req_single,
    input  logic [7:0] req_data,
    input  logic       flag_in,
    output logic       rs,
    output logic       rw,
    output logic       en,
    output logic [7:0] dout,
    output logic       doe,
    output logic       ack,
    output logic       flag
);
    localparam int PH_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int PH_MAX = (PH_A > HOLD_CYC) ? PH_A : HOLD_CYC;
    localparam int CW     = $clog2(PH_MAX + 1);

    xfer_phase_e phase;
    logic [CW-1:0] cnt;
    logic [7:0]    sh;
    logic          rw_q, nib_q, two_q, second;

    // Bus pins follow the phase; lines are parked at zero when idle
    always_comb begin
        en   = (phase == PH_PULSE);
        rs   = 1'b0;
        rw   = (phase != PH_IDLE) && rw_q;
        doe  = (phase != PH_IDLE) && !rw_q;
        dout = 8'h00;
        if (phase != PH_IDLE && !rw_q)
            dout = nib_q ? {sh[7:4], 4'b0000} : sh;
    end

    // Phase sequencing, nibble shifting and flag capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            sh     <= '0;
            rw_q   <= 1'b0;
            nib_q  <= 1'b0;
            two_q  <= 1'b0;
            second <= 1'b0;
            ack    <= 1'b0;
            flag   <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        rw_q   <= req_rd;
                        nib_q  <= req_nib;
                        two_q  <= req_nib && !req_single;
                        second <= 1'b0;
                        sh     <= req_data;
                        phase  <= PH_SETUP;
                        cnt    <= CW'(SETUP_CYC - 1);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_PULSE;
                        cnt   <= CW'(PULSE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == '0) begin
                        if (!second) flag <= flag_in;
                        phase <= PH_HOLD;
                        cnt   <= CW'(HOLD_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (two_q && !second) begin
                        second <= 1'b1;
                        sh     <= {sh[3:0], 4'b0000};
                        phase  <= PH_SETUP;
                        cnt    <= CW'(SETUP_CYC - 1);
                    end else begin
                        phase <= PH_IDLE;
                        ack   <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/disp_wait_timer.sv
// Down-counting delay: a load starts it, fin pulses once at least 'value'
// cycles later. Assumes value >= 1 and no load while running.
module disp_wait_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          fin
);
    logic [TW-1:0] cnt;
    logic          run;

    // Count down from the loaded value and flag the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                cnt <= value;
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= TW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/disp_init_seq.sv
// Host-side initialization sequencer for a parallel character display.
// Runs power-up wait, three blind wake writes, the optional 4-bit mode nibble,
// then four configuration bytes each followed by a bounded busy poll.
// Assumes the display answers busy on data line 7 and that cfg inputs are
// valid in the cycle start is high.
module disp_init_seq
    import disp_init_pkg::*;
#(
    parameter int CLK_KHZ     = 50000,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 12,
    parameter int HOLD_CYC    = 2,
    parameter int POLL_MAX    = 1000,
    parameter int FALLBACK_US = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cfg_bus8,
    input  logic       cfg_two_line,
    input  logic       cfg_tall_font,
    input  logic       cfg_addr_incr,
    input  logic       cfg_auto_shift,
    input  logic       lcd_flag_in,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_dout,
    output logic       lcd_doe,
    output logic       done,
    output logic       poll_timeout
);
    localparam int PWRUP_CYC = CLK_KHZ * 15;
    localparam int GAP1_RAW  = (CLK_KHZ * 41 + 9) / 10;
    localparam int GAP2_RAW  = (CLK_KHZ + 9) / 10;
    localparam int FALL_RAW  = (CLK_KHZ * FALLBACK_US + 999) / 1000;
    localparam int GAP1_CYC  = (GAP1_RAW < 1) ? 1 : GAP1_RAW;
    localparam int GAP2_CYC  = (GAP2_RAW < 1) ? 1 : GAP2_RAW;
    localparam int FALL_CYC  = (FALL_RAW < 1) ? 1 : FALL_RAW;
    localparam int MAX_A     = (PWRUP_CYC > GAP1_CYC) ? PWRUP_CYC : GAP1_CYC;
    localparam int MAX_W     = (MAX_A > FALL_CYC) ? MAX_A : FALL_CYC;
    localparam int TW        = $clog2(MAX_W + 1);
    localparam int PW        = $clog2(POLL_MAX + 1);

    seq_state_e    state, nxt_state;
    logic          pend, after_nib;
    logic [1:0]    wk, idx, nxt_idx;
    logic [PW-1:0] pcnt;
    logic          bus8_q, two_q, tall_q, incr_q, shift_q;
    logic          done_q, err_q;

    logic          x_req, x_rd, x_single, x_ack, x_flag;
    logic [7:0]    x_data;
    logic          t_load, t_fin;
    logic [TW-1:0] t_value;

    // Request decode: one transfer or one wait per state visit
    always_comb begin
        x_req    = 1'b0;
        t_load   = 1'b0;
        x_rd     = (state == ST_POLL);
        x_single = (state == ST_WAKE) || (state == ST_NIB);
        x_data   = 8'h00;
        t_value  = TW'(PWRUP_CYC);
        case (state)
            ST_PWR:       t_load = !pend;
            ST_WAKE:      begin x_req = !pend; x_data = WAKE_CODE; end
            ST_WAKE_WAIT: begin
                t_load  = !pend;
                t_value = (wk == 2'd0) ? TW'(GAP1_CYC) : TW'(GAP2_CYC);
            end
            ST_NIB:       begin x_req = !pend; x_data = MODE4_CODE; end
            ST_CMD:       begin
                x_req  = !pend;
                x_data = cfg_byte(idx, bus8_q, two_q, tall_q, incr_q, shift_q);
            end
            ST_POLL:      x_req = !pend;
            ST_FALLBACK:  begin t_load = !pend; t_value = TW'(FALL_CYC); end
            default:      ;
        endcase
    end

    // Next step after a poll succeeds or its fallback ends
    always_comb begin
        nxt_idx = idx;
        if (after_nib) begin
            nxt_state = ST_CMD;
            nxt_idx   = 2'd0;
        end else if (idx == 2'd3) begin
            nxt_state = ST_DONE;
        end else begin
            nxt_state = ST_CMD;
            nxt_idx   = idx + 2'd1;
        end
    end

    // Main sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend      <= 1'b0;
            after_nib <= 1'b0;
            wk        <= '0;
            idx       <= '0;
            pcnt      <= '0;
            bus8_q    <= 1'b1;
            two_q     <= 1'b0;
            tall_q    <= 1'b0;
            incr_q    <= 1'b0;
            shift_q   <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (x_req || t_load) pend <= 1'b1;
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        bus8_q    <= cfg_bus8;
                        two_q     <= cfg_two_line;
                        tall_q    <= cfg_tall_font;
                        incr_q    <= cfg_addr_incr;
                        shift_q   <= cfg_auto_shift;
                        done_q    <= 1'b0;
                        err_q     <= 1'b0;
                        wk        <= '0;
                        idx       <= '0;
                        after_nib <= 1'b0;
                        pend      <= 1'b0;
                        state     <= ST_PWR;
                    end
                end
                ST_PWR: if (t_fin) begin
                    pend  <= 1'b0;
                    state <= ST_WAKE;
                end
                ST_WAKE: if (x_ack) begin
                    pend  <= 1'b0;
                    state <= ST_WAKE_WAIT;
                end
                ST_WAKE_WAIT: if (t_fin) begin
                    pend <= 1'b0;
                    if (wk == 2'd2) begin
                        state <= bus8_q ? ST_CMD : ST_NIB;
                    end else begin
                        wk    <= wk + 2'd1;
                        state <= ST_WAKE;
                    end
                end
                ST_NIB: if (x_ack) begin
                    pend      <= 1'b0;
                    after_nib <= 1'b1;
                    pcnt      <= '0;
                    state     <= ST_POLL;
                end
                ST_CMD: if (x_ack) begin
                    pend  <= 1'b0;
                    pcnt  <= '0;
                    state <= ST_POLL;
                end
                ST_POLL: if (x_ack) begin
                    pend <= 1'b0;
                    if (!x_flag) begin
                        state     <= nxt_state;
                        idx       <= nxt_idx;
                        after_nib <= 1'b0;
                        if (nxt_state == ST_DONE) done_q <= 1'b1;
                    end else if (pcnt == PW'(POLL_MAX - 1)) begin
                        err_q <= 1'b1;
                        state <= ST_FALLBACK;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                ST_FALLBACK: if (t_fin) begin
                    pend      <= 1'b0;
                    state     <= nxt_state;
                    idx       <= nxt_idx;
                    after_nib <= 1'b0;
                    if (nxt_state == ST_DONE) done_q <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done         = done_q;
    assign poll_timeout = err_q;

    disp_bus_xfer #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) i_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (x_req),
        .req_rd     (x_rd),
        .req_nib    (!bus8_q),
        .req_single (x_single),
        .req_data   (x_data),
        .flag_in    (lcd_flag_in),
        .rs         (lcd_rs),
        .rw         (lcd_rw),
        .en         (lcd_en),
        .dout       (lcd_dout),
        .doe        (lcd_doe),
        .ack        (x_ack),
        .flag       (x_flag)
    );

    disp_wait_timer #(
        .TW (TW)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .value (t_value),
        .fin   (t_fin)
    );

endmodule

// File: rtl/disp_init_seq_chk.sv
// Protocol checker for the initialization sequencer, attached by bind.
// Assumes only the top-level pins; no internal state is observed.
module disp_init_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_en,
    input logic [7:0] lcd_dout,
    input logic       lcd_doe,
    input logic       done,
    input logic       poll_timeout
);
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en && lcd_rw |-> !lcd_doe); // R9
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en && !lcd_rw |-> lcd_doe); // R9
    AST_EN_LINES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en && $past(lcd_en) |-> $stable(lcd_dout) && $stable(lcd_rs) && $stable(lcd_rw)); // R8
    AST_INSTR_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |-> !lcd_rs); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lcd_en); // R10
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R10
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        poll_timeout && !start |=> poll_timeout); // R7
endmodule

bind disp_init_seq disp_init_seq_chk i_disp_init_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .lcd_rs       (lcd_rs),
    .lcd_rw       (lcd_rw),
    .lcd_en       (lcd_en),
    .lcd_dout     (lcd_dout),
    .lcd_doe      (lcd_doe),
    .done         (done),
    .poll_timeout (poll_timeout)
);

// File: tb/test_disp_init_seq.sv
module test_disp_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ  = 4;
    localparam int SET  = 2;
    localparam int PUL  = 3;
    localparam int HLD  = 2;
    localparam int PMAX = 4;
    localparam int FBUS = 2000;
    // Expected waits derived from the millisecond figures
    localparam int PWR  = KHZ * 15;
    localparam int GAP1 = (KHZ * 41 + 9) / 10;
    localparam int GAP2 = (KHZ + 9) / 10;
    localparam int FB   = (KHZ * FBUS + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_bus8 = 1'b1, cfg_two_line = 1'b0, cfg_tall_font = 1'b0;
    logic cfg_addr_incr = 1'b0, cfg_auto_shift = 1'b0;
    logic lcd_flag_in = 1'b0;
    logic lcd_rs, lcd_rw, lcd_en, lcd_doe, done, poll_timeout;
    logic [7:0] lcd_dout;

    disp_init_seq #(
        .CLK_KHZ(KHZ), .SETUP_CYC(SET), .PULSE_CYC(PUL), .HOLD_CYC(HLD),
        .POLL_MAX(PMAX), .FALLBACK_US(FBUS)
    ) i_disp_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_bus8(cfg_bus8), .cfg_two_line(cfg_two_line), .cfg_tall_font(cfg_tall_font),
        .cfg_addr_incr(cfg_addr_incr), .cfg_auto_shift(cfg_auto_shift),
        .lcd_flag_in(lcd_flag_in), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
        .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .done(done), .poll_timeout(poll_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cycle = 0;
    always @(posedge clk) cycle <= cycle + 1;

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model state
    int  exp_val[$];
    int  exp_kind[$];   // 0 wake, 1 mode nibble, 2 first half, 3 end of byte
    bit  active = 0, mode4 = 0, poll_req = 0, timeout_pend = 0, exp_err = 0;
    bit  rd_phase = 0, seen_busy = 0, stuck_now = 0, first_rise = 0, nib_seen = 0;
    bit  hold_open = 0, en_q = 0;
    int  busy_n = 0, stuck_idx = -1, cmd_no = -1, poll_cnt = 0, busy_left = 0;
    int  last_fall = 0, last_kind = -1, wake_no = 0, wr_cnt = 0, start_t = 0;
    int  hi_cnt = 0, stable_cnt = 0, hold_cnt = 0;
    logic [10:0] prev_lines = '0;

    // Per-clock comparison of the bus against the reference model
    always @(negedge clk) begin
        if (rst_n && active) begin
            logic [10:0] lines;
            bit busy_now;
            lines = {lcd_rs, lcd_rw, lcd_doe, lcd_dout};
            if (lines != prev_lines) begin
                if (hold_open) begin
                    check(hold_cnt >= HLD, "R8 hold after strobe", hold_cnt, HLD);
                    hold_open = 0;
                end
                stable_cnt = 1;
            end else begin
                stable_cnt++;
                if (hold_open && !lcd_en) hold_cnt++;
            end

            if (lcd_en && !en_q) begin
                hold_open = 0;
                check(stable_cnt >= SET + 1, "R8 setup before strobe", stable_cnt - 1, SET);
                check(lcd_doe == !lcd_rw, "R9 drive enable", lcd_doe, !lcd_rw);
                check(!done, "R10 no strobe after done", done, 0);
                if (lcd_rw) begin
                    if (!poll_req)
                        check(0, (wake_no < 3 || (mode4 && !nib_seen)) ? "R3 read too early"
                                 : "R6 read without pending poll", 1, 0);
                end else begin
                    if (poll_req) check(0, "R6 write before flag cleared", 1, 0);
                    if (mode4 && rd_phase) check(0, "R6 split status read", 1, 0);
                    if (timeout_pend) begin
                        check(poll_timeout == 1'b1, "R7 timeout flag", poll_timeout, 1);
                        check(cycle - last_fall >= FB, "R7 fallback wait", cycle - last_fall, FB);
                        timeout_pend = 0;
                    end
                    if (!first_rise)
                        check(cycle - start_t >= PWR, "R1 power-up wait", cycle - start_t, PWR);
                    else if (last_kind == 0)
                        check(cycle - last_fall >= ((wake_no == 1) ? GAP1 : GAP2),
                              "R2 wake gap", cycle - last_fall, (wake_no == 1) ? GAP1 : GAP2);
                    stuck_now = 0;
                    wr_cnt++;
                    if (exp_val.size() == 0) begin
                        check(0, "R5 unexpected write", lcd_dout, 0);
                        last_kind = 3;
                    end else begin
                        int ev, ek;
                        ev = exp_val.pop_front();
                        ek = exp_kind.pop_front();
                        check(lcd_rs == 1'b0 && lcd_dout == ev[7:0],
                              ek == 0 ? "R2 wake write" : (ek == 1 ? "R4 mode nibble" :
                              (mode4 ? "R4 nibble write" : "R5 command byte")), lcd_dout, ev);
                        last_kind = ek;
                    end
                end
                first_rise = 1;
            end

            if (lcd_en) hi_cnt++;

            if (!lcd_en && en_q) begin
                check(hi_cnt == PUL, "R8 strobe width", hi_cnt, PUL);
                hi_cnt = 0;
                last_fall = cycle;
                hold_open = 1;
                hold_cnt = 1;
                if (lines[9]) begin
                    if (mode4 && !rd_phase) rd_phase = 1;
                    else begin
                        rd_phase = 0;
                        if (!seen_busy) begin
                            poll_req = 0;
                            poll_cnt = 0;
                        end else begin
                            poll_cnt++;
                            if (poll_cnt == PMAX) begin
                                poll_req = 0;
                                poll_cnt = 0;
                                timeout_pend = 1;
                                exp_err = 1;
                            end
                        end
                    end
                end else begin
                    if (last_kind == 0) wake_no++;
                    if (last_kind == 1) begin
                        nib_seen = 1;
                        poll_req = 1;
                        busy_left = busy_n;
                    end
                    if (last_kind == 3) begin
                        poll_req = 1;
                        busy_left = busy_n;
                        cmd_no++;
                        stuck_now = (cmd_no == stuck_idx);
                    end
                end
            end

            prev_lines = lines;
            en_q = lcd_en;
            if (busy_left > 0) busy_left--;
            busy_now = stuck_now || (busy_left > 0);
            lcd_flag_in = (rd_phase == 0) ? busy_now : !busy_now;
            if (lcd_en && lcd_rw && rd_phase == 0) seen_busy = busy_now;
        end
    end

    task automatic run_seq(input bit m4, input bit two, input bit tall, input bit inc,
                           input bit sh, input int bn, input int stk, input bit mid_start);
        int c[4];
        int n_wr;
        c[0] = 32'h20 | (m4 ? 0 : 32'h10) | (int'(two) << 3) | (int'(tall) << 2);
        c[1] = 32'h08;
        c[2] = 32'h01;
        c[3] = 32'h04 | (int'(inc) << 1) | int'(sh);
        exp_val.delete();
        exp_kind.delete();
        repeat (3) begin exp_val.push_back(32'h30); exp_kind.push_back(0); end
        if (m4) begin exp_val.push_back(32'h20); exp_kind.push_back(1); end
        foreach (c[i]) begin
            if (m4) begin
                exp_val.push_back(c[i] & 32'hF0);        exp_kind.push_back(2);
                exp_val.push_back((c[i] << 4) & 32'hF0); exp_kind.push_back(3);
            end else begin
                exp_val.push_back(c[i]); exp_kind.push_back(3);
            end
        end
        n_wr = exp_val.size();
        mode4 = m4; busy_n = bn; stuck_idx = stk; cmd_no = -1;
        poll_req = 0; timeout_pend = 0; exp_err = 0; rd_phase = 0; seen_busy = 0;
        stuck_now = 0; first_rise = 0; nib_seen = 0; poll_cnt = 0; busy_left = 0;
        last_kind = -1; wake_no = 0; wr_cnt = 0; hi_cnt = 0;
        cfg_bus8 = !m4; cfg_two_line = two; cfg_tall_font = tall;
        cfg_addr_incr = inc; cfg_auto_shift = sh;
        @(negedge clk);
        start = 1'b1;
        start_t = cycle;
        active = 1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && poll_timeout == 1'b0, "R10 start clears flags",
              {done, poll_timeout}, 0);
        if (mid_start) begin
            repeat (120) @(negedge clk);
            cfg_bus8 = m4;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
        check(done == 1'b1, "R10 done raised", done, 1);
        check(exp_val.size() == 0, "R5 all bytes sent", exp_val.size(), 0);
        check(poll_timeout == exp_err, "R7 timeout flag at end", poll_timeout, exp_err);
        check(wr_cnt == n_wr, "R11 write count", wr_cnt, n_wr);
        repeat (20) @(negedge clk);
        check(done == 1'b1 && wr_cnt == n_wr, "R10 quiet after done", wr_cnt, n_wr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(lcd_en == 1'b0 && lcd_doe == 1'b0, "R10 reset bus idle", {lcd_en, lcd_doe}, 0);
        check(done == 1'b0 && poll_timeout == 1'b0, "R10 reset flags", {done, poll_timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // 8-bit, short busy, stray start mid-run
        run_seq(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12, -1, 1'b1);
        // 4-bit, longer busy
        run_seq(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20, -1, 1'b0);
        // 4-bit, flag stuck after clear
        run_seq(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5, 2, 1'b0);
        // 8-bit, flag stuck after function set
        run_seq(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule